// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Channel

This block is a single pulse-width-modulation timer channel. A down counter steps once per tick enable supplied by an external prescaler. A period buffer and a duty buffer, both written over a simple register port, set the waveform. The buffers are shadow values: the live counter and the live compare value take them only on a software-forced load or on an automatic reload when the counter has run out. So software can rewrite the buffers at any time without disturbing the period that is in progress.

Inside the channel a raw level is cleared whenever the counter is loaded. It is set when the counter reaches the live compare value. A polarity bit then selects whether the pin shows the raw level or its complement. A compare value of all ones can never match, which gives a full-duty waveform. When the counter steps down to zero, the channel emits a one-cycle expiry pulse. Whether it reloads or stops at that point depends on the auto-reload bit.

Top module: `pwm_chan`

## Requirements
- R1: After reset the control field reads 4'b0100 (bit0 run, bit1 force-load, bit2 polarity invert, bit3 auto-reload), both buffers and the live counter read zero, `expire` is low and `pwm_out` is high.
- R2: Selector code 0 addresses the period buffer, 1 the duty buffer and 2 the control field (its low four bits). Writes use these codes on `wr_sel`. Reads on `rd_sel` return the same registers, and code 3 returns the live counter.
- R3: While the force-load bit is set, the live counter and live compare take the buffer values on every clock, the raw level is set to the match result of those two values, and counting is suspended.
- R4: The counter decrements by one only on a clock with `tick` high while run is set and force-load is clear. Otherwise it holds its value.
- R5: With auto-reload set and period buffer N, the counter runs N..0 and spans N+1 ticks. `expire` is high for exactly one clock, in the cycle when the counter has just stepped to zero.
- R6: With duty buffer C (C <= N), `pwm_out` is high for N-C ticks per period when the invert bit is set, and for C+1 ticks when it is clear.
- R7: Writing a buffer does not change the live counter. The new value takes effect only at the next reload or forced load.
- R8: With auto-reload clear, the tick that finds the counter at zero clears the run bit. The counter stays at zero and no further expiry pulses occur.
- R9: A compare value of all ones never matches. With the invert bit set, `pwm_out` stays high for the whole period and keeps that level after the channel stops.
- R10: A forced load with equal period and duty buffers sets the raw level at once, so a stopped full-duty channel can be parked at its inactive level (low when inverted).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written (0 period, 1 duty, 2 control) |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Register read (0 period, 1 duty, 2 control, 3 live counter) |
| rd_data | output | CNT_W | Read data, combinational |
| pwm_out | output | 1 | PWM pin after polarity |
| expire | output | 1 | One-cycle pulse when the counter reaches zero |

## Verification
The assertions assume that `tick` is a clean single-cycle enable. They also assume that software writes the control field on one clock, so a write and a hardware stop may coincide and the write wins. The stimulus never programs a period buffer of zero while the channel runs, because that configuration is invalid. It keeps C at or below N except in the all-ones case, and it forces a load before each run so that every measured period starts from known live values. Measurements start only at an expiry pulse after configuration, so a partial first period is never scored.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_LIVE   = 2'd3
  } sel_e;

  // bit3 auto-reload, bit2 invert, bit1 force-load, bit0 run
  typedef struct packed {
    logic reload;
    logic inv;
    logic load;
    logic run;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{reload: 1'b0, inv: 1'b1, load: 1'b0, run: 1'b0};
  localparam int   CTL_W     = 4;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  input  logic             stop_evt,
  input  logic [CNT_W-1:0] live_cnt,
  output logic [CNT_W-1:0] period_buf,
  output logic [CNT_W-1:0] duty_buf,
  output ctl_t             ctl,
  output logic [CNT_W-1:0] rd_data
);

  localparam int PAD_W = CNT_W - CTL_W;

  logic ctl_wr;
  assign ctl_wr = wr_en && (sel_e'(wr_sel) == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_buf <= '0;
      duty_buf   <= '0;
      ctl        <= CTL_RESET;
    end else begin
      if (wr_en && sel_e'(wr_sel) == SEL_PERIOD) period_buf <= wr_data;
      if (wr_en && sel_e'(wr_sel) == SEL_DUTY)   duty_buf   <= wr_data;
      if (ctl_wr)        ctl     <= ctl_t'(wr_data[CTL_W-1:0]);
      else if (stop_evt) ctl.run <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel_e'(rd_sel))
      SEL_PERIOD: rd_data = period_buf;
      SEL_DUTY:   rd_data = duty_buf;
      SEL_CTRL:   rd_data = {{PAD_W{1'b0}}, ctl};
      default:    rd_data = live_cnt;
    endcase
  end

  // R8: a stop with no competing control write leaves run cleared
  a_r8_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !ctl_wr) |=> !ctl.run);

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic             reload,
  input  logic [CNT_W-1:0] period_buf,
  input  logic [CNT_W-1:0] duty_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic             raw_q,
  output logic             expire_q,
  output logic             stop_evt
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ZERO     = '0;

  // A compare of all ones is the full-duty code and never matches.
  function automatic logic hits(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return (c == m) && (m != ALL_ONES);
  endfunction

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] next_dec;
  logic             advance, at_zero, reload_evt, dec_evt;

  always_comb begin
    at_zero    = (cnt_q == ZERO);
    advance    = run && !load && tick;
    reload_evt = advance && at_zero && reload;
    stop_evt   = advance && at_zero && !reload;
    dec_evt    = advance && !at_zero;
    next_dec   = step_down(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= ZERO;
      cmp_q    <= ZERO;
      raw_q    <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load || reload_evt) begin
        cnt_q <= period_buf;
        cmp_q <= duty_buf;
        raw_q <= hits(period_buf, duty_buf);
      end else if (dec_evt) begin
        cnt_q <= next_dec;
        if (hits(next_dec, cmp_q)) raw_q    <= 1'b1;
        if (next_dec == ZERO)      expire_q <= 1'b1;
      end
    end
  end

  // R3: forced load copies both buffers into the live registers
  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(period_buf) && cmp_q == $past(duty_buf)));

  // R4: no tick and no load means the counter holds
  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

  // R5: the expiry pulse coincides with a zero counter and lasts one clock
  a_r5_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (cnt_q == ZERO));
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);

  // R9: the raw level never rises against an all-ones compare
  a_r9_no_allones_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> (cmp_q != ALL_ONES && cnt_q == cmp_q));

endmodule

// File: rtl/pwm_chan_polarity.sv
module pwm_chan_polarity (
  input  logic raw,
  input  logic inv,
  output logic pin
);

  // invert set: pin is high while the raw level is low
  assign pin = raw ^ inv;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out,
  output logic             expire
);

  ctl_t             ctl;
  logic [CNT_W-1:0] period_buf, duty_buf, live_cnt;
  logic             raw, stop_evt;

  pwm_chan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .stop_evt   (stop_evt),
    .live_cnt   (live_cnt),
    .period_buf (period_buf),
    .duty_buf   (duty_buf),
    .ctl        (ctl),
    .rd_data    (rd_data)
  );

  pwm_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (ctl.run),
    .load       (ctl.load),
    .reload     (ctl.reload),
    .period_buf (period_buf),
    .duty_buf   (duty_buf),
    .cnt_q      (live_cnt),
    .raw_q      (raw),
    .expire_q   (expire),
    .stop_evt   (stop_evt)
  );

  pwm_chan_polarity u_pol (
    .raw (raw),
    .inv (ctl.inv),
    .pin (pwm_out)
  );

endmodule

// File: tb/pwm_chan_test.sv
module pwm_chan_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_sel = 2'd0;
  logic [W-1:0] rd_data;
  logic         pwm_out, expire;

  pwm_chan #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .pwm_out(pwm_out), .expire(expire)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct { int per; int hi; string tag; } item_t;
  item_t exp_q[$];

  // tick generator
  int tick_div = 1;
  bit tick_en  = 1;
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = ph + 1;
      tick = tick_en && (ph % tick_div == 0);
    end
  end

  int pulse_cnt = 0;
  bit mon_on = 0;
  bit have_last = 0;
  int per_cnt = 0;
  int hi_cnt = 0;

  task automatic check(input string tag, input int got, input int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, want);
    end
  endtask

  // monitor: one window per period, starting at each expiry pulse
  always @(posedge clk) begin
    #1;
    if (expire) pulse_cnt++;
    if (mon_on) begin
      if (expire) begin
        if (have_last && exp_q.size() != 0) begin
          item_t e;
          e = exp_q.pop_front();
          check({e.tag, " period"}, per_cnt, e.per);
          check({e.tag, " high"}, hi_cnt, e.hi);
        end
        have_last = 1;
        per_cnt = 1;
        hi_cnt = pwm_out ? 1 : 0;
      end else begin
        per_cnt++;
        if (pwm_out) hi_cnt++;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    @(negedge clk);
    rd_sel = s;
    #1;
    v = int'(rd_data);
  endtask

  function automatic logic [W-1:0] ctlv(input bit rl, input bit inv, input bit ld, input bit rn);
    return W'({rl, inv, ld, rn});
  endfunction

  task automatic configure(input int n, input int c, input bit inv);
    wr(2'd2, ctlv(0, inv, 0, 0));
    wr(2'd0, W'(n));
    wr(2'd1, W'(c));
    wr(2'd2, ctlv(0, inv, 1, 0));
    @(negedge clk);
    wr(2'd2, ctlv(1, inv, 0, 1));
  endtask

  task automatic expect_periods(input int k, input int per, input int hi, input string tag);
    for (int i = 0; i < k; i++) begin
      item_t e;
      e.per = per; e.hi = hi; e.tag = tag;
      exp_q.push_back(e);
    end
    have_last = 0;
    mon_on = 1;
    while (exp_q.size() != 0) @(negedge clk);
    mon_on = 0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      report();
    end
  end

  initial begin
    int v, v2, pc0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd2, v); check("R1 control", v, 4);
    rd(2'd0, v); check("R1 period buffer", v, 0);
    rd(2'd3, v); check("R1 live counter", v, 0);
    check("R1 pwm_out", int'(pwm_out), 1);
    check("R1 expire", int'(expire), 0);

    // R2 readback
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h00AB);
    rd(2'd0, v); check("R2 period readback", v, 'h1234);
    rd(2'd1, v); check("R2 duty readback", v, 'hAB);

    // R3 forced load, counting suspended
    wr(2'd0, 16'd12);
    wr(2'd2, ctlv(0, 1, 1, 1));
    rd(2'd3, v); check("R3 live after load", v, 12);
    repeat (5) @(negedge clk);
    rd(2'd3, v); check("R3 held during load", v, 12);
    rd(2'd2, v); check("R2 control readback", v, 7);

    // R5/R6 main waveforms
    configure(9, 3, 1);
    expect_periods(3, 10, 6, "R5 R6 N9 C3");

    // R7 buffer write does not touch live counter
    wr(2'd0, 16'd20);
    rd(2'd3, v); check("R7 live within old period", int'(v <= 9), 1);
    expect_periods(2, 21, 17, "R7 new period after reload");

    // R4 tick gating
    tick_en = 0;
    repeat (2) @(negedge clk);
    rd(2'd3, v);
    repeat (6) @(negedge clk);
    rd(2'd3, v2); check("R4 hold without tick", v2, v);
    tick_en = 1;

    configure(4, 0, 1);
    expect_periods(2, 5, 4, "R6 C0");
    configure(6, 6, 1);
    expect_periods(2, 7, 0, "R6 R10 C equals N");
    configure(9, 3, 0);
    expect_periods(2, 10, 4, "R6 invert clear");
    tick_div = 2;
    configure(5, 2, 1);
    expect_periods(2, 12, 6, "R4 R5 tick every other clock");
    tick_div = 1;

    // R8 stop without auto-reload
    configure(9, 3, 1);
    repeat (5) @(negedge clk);
    wr(2'd2, ctlv(0, 1, 0, 1));
    repeat (25) @(negedge clk);
    pc0 = pulse_cnt;
    repeat (15) @(negedge clk);
    check("R8 no pulses after stop", pulse_cnt, pc0);
    rd(2'd2, v); check("R8 run cleared", v, 4);
    rd(2'd3, v); check("R8 counter parked at zero", v, 0);

    // R9 full duty
    configure(7, 'hFFFF, 1);
    expect_periods(2, 8, 8, "R9 all-ones compare");
    wr(2'd2, ctlv(0, 1, 0, 1));
    repeat (20) @(negedge clk);
    check("R9 stays high after stop", int'(pwm_out), 1);

    // R10 park inactive with forced load, C equal N
    wr(2'd1, 16'd7);
    wr(2'd2, ctlv(0, 1, 1, 0));
    repeat (2) @(negedge clk);
    check("R10 low after forced load", int'(pwm_out), 0);
    wr(2'd2, ctlv(0, 1, 0, 0));
    repeat (3) @(negedge clk);
    check("R10 stays low", int'(pwm_out), 0);

    finished = 1;
    report();
  end

endmodule